// File: doc/BRIEF.md
# Stereo Serial Audio Slave Receiver

This block takes a three-wire stereo serial audio stream from an external master and turns it into parallel 16-bit PCM sample pairs. The master owns both the bit clock and the word-select line. The receiver samples them, together with the data line, inside a faster system clock domain. It finds rising bit-clock edges, tracks which channel is active, and counts bit positions inside each channel slot.

Every channel slot is 32 bit clocks long and is sent MSB first. Word select low marks the left channel, and high marks the right channel. The left slot comes before the right slot in a frame. A configuration input picks the alignment between the word-select edge and the MSB. In standard mode the MSB arrives one bit clock after the edge. In left-justified mode the MSB arrives on the same bit clock as the edge. The top 16 bits of each slot are kept as the sample. When the right slot of a complete frame ends, both samples appear together with a one-cycle valid pulse.

Top module: `i2s_slave_rx`

## Requirements
- R1: While reset is low and in the first cycle after it, `pair_valid` is 0 and `left_pcm` and `right_pcm` are 0.
- R2: Word select and data are taken only at rising bit-clock edges. Changes on the data line while the bit clock is high have no effect on the samples produced.
- R3: With `msb_justified` = 0 (standard alignment), the slot's MSB is the bit sampled one bit clock after the sample where word select changed.
- R4: With `msb_justified` = 1, the slot's MSB is the bit sampled at the first rising edge where the new word-select level is seen.
- R5: A slot taken while word select is low (after the mode's alignment) is delivered on `left_pcm`, and a slot taken while it is high is delivered on `right_pcm`. A pair is a left slot followed by the right slot after it.
- R6: Each output word is the first 16 bits of its 32-bit slot, with the first received bit at bit 15. The last 16 bits of the slot do not affect the output.
- R7: `pair_valid` is high for exactly one system cycle. That cycle starts `SYNC_STAGES`+1 system clock edges after the rising bit-clock edge that carries the 32nd bit of the right slot.
- R8: `left_pcm` and `right_pcm` change only in a cycle where `pair_valid` is high. At all other times they hold their values.
- R9: No pair is produced when the left slot was cut short before its 16th bit, or when the right slot ends before its 32nd bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit-clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| msb_justified | input | 1 | 0: MSB one bit after the word-select edge; 1: MSB on the edge |
| bclk_in | input | 1 | Bit clock from the external master |
| ws_in | input | 1 | Word select from the master, low = left, high = right |
| sd_in | input | 1 | Serial data, MSB first |
| left_pcm | output | 16 | Left sample of the last completed pair |
| right_pcm | output | 16 | Right sample of the last completed pair |
| pair_valid | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
The stream uses words with their MSB and LSB set against each other, such as 0x8000_0001 against 0x7FFF_FFFE, alternating patterns, and words whose upper and lower halves differ. A one-bit slip in alignment, a left/right swap, or keeping the wrong half of the slot therefore changes the output. The same frames run in both alignment modes, so a design that ignores the mode input fails in one of them. Frames with a short left slot and a short right slot are mixed between good frames to show that a partial slot never yields a pair. The data line is inverted during each bit-clock high phase to show that only the rising edge is sampled. Every expected pulse is tied to an exact system cycle, so any extra or late pulse is reported.

// File: rtl/i2s_rx_pkg.sv
// Shared constants and types for the serial audio receiver.
package i2s_rx_pkg;
    localparam int SLOT_BITS_DEF   = 32;  // bit clocks per channel slot
    localparam int PCM_BITS_DEF    = 16;  // bits kept per sample
    localparam int SYNC_STAGES_DEF = 2;   // synchronizer depth

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/i2s_rx_sync.sv
// Synchronizes the three serial lines into the system clock domain.
// It gives a one-cycle strobe on each rising bit-clock edge, plus the
// word-select and data values that were captured with that edge.
// Assumes the system clock is fast enough that each bit-clock phase
// lasts several system cycles.
module i2s_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic bit_rise,
    output logic ws_s,
    output logic sd_s
);
    localparam int LAST = STAGES - 1;

    logic [2:0] stage_q [STAGES];
    logic       bclk_prev;

    // Move all three lines through the same number of flops so they stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            bclk_prev <= 1'b0;
        end else begin
            stage_q[0] <= {bclk_in, ws_in, sd_in};
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            bclk_prev <= stage_q[LAST][2];
        end
    end

    // Rising edge: the synchronized bit clock is high now and was low one cycle ago.
    assign bit_rise = stage_q[LAST][2] & ~bclk_prev;
    assign ws_s     = stage_q[LAST][1];
    assign sd_s     = stage_q[LAST][0];
endmodule

// File: rtl/i2s_rx_framer.sv
// Works out which channel each received bit belongs to, finds slot
// starts, and counts bit positions within the current slot. In standard
// mode it uses word select delayed by one bit, so the MSB always lands at
// position 0. The first two bit edges after reset only learn the line
// levels. A counter parked at SLOT_BITS means "no slot in progress".
module i2s_rx_framer
    import i2s_rx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msb_justified,
    input  logic             bit_rise,
    input  logic             ws_s,
    output chan_e            chan,
    output logic             slot_start,
    output logic [CNT_W-1:0] slot_cnt
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SLOT_BITS);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic       ws_d1;
    chan_e      chan_prev;
    logic [1:0] prime_q;
    logic       primed;

    // Channel of the bit being taken now, after the mode's alignment.
    assign chan       = chan_e'(msb_justified ? ws_s : ws_d1);
    assign primed     = prime_q[1];
    assign slot_start = bit_rise && primed && (chan != chan_prev);

    // Keep the word-select history, the priming count and the bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_d1     <= 1'b0;
            chan_prev <= CH_LEFT;
            prime_q   <= 2'd0;
            slot_cnt  <= CNT_FULL;
        end else if (bit_rise) begin
            ws_d1     <= ws_s;
            chan_prev <= chan;
            if (!primed) prime_q <= prime_q + 2'd1;
            if (slot_start)
                slot_cnt <= CNT_ONE;
            else if (slot_cnt != CNT_FULL)
                slot_cnt <= slot_cnt + CNT_ONE;
        end
    end
endmodule

// File: rtl/i2s_rx_assembler.sv
// Collects the leading PCM_BITS of each slot into a holding register for
// its channel. It presents the pair when the right slot's final bit
// arrives, but only if the left slot of the same frame reached PCM_BITS.
// Assumes 2 <= PCM_BITS <= SLOT_BITS.
module i2s_rx_assembler
    import i2s_rx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int PCM_BITS  = 16,
    parameter int CNT_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_rise,
    input  logic                slot_start,
    input  chan_e               chan,
    input  logic [CNT_W-1:0]    slot_cnt,
    input  logic                sd_s,
    output logic                pair_valid,
    output logic [PCM_BITS-1:0] left_pcm,
    output logic [PCM_BITS-1:0] right_pcm
);
    localparam logic [CNT_W-1:0] LAST_PCM  = CNT_W'(PCM_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOT_BITS - 1);

    logic [PCM_BITS-2:0] shreg;
    logic [PCM_BITS-1:0] word;
    logic [PCM_BITS-1:0] left_hold;
    logic [PCM_BITS-1:0] right_hold;
    logic                left_ok;
    logic                word_done;
    logic                frame_done;

    assign word       = {shreg, sd_s};
    assign word_done  = bit_rise && !slot_start && (slot_cnt == LAST_PCM);
    assign frame_done = bit_rise && !slot_start && (chan == CH_RIGHT)
                        && (slot_cnt == LAST_SLOT) && left_ok;

    // Shift in the first bits of a slot and keep them once the sample is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            left_hold  <= '0;
            right_hold <= '0;
            left_ok    <= 1'b0;
        end else if (bit_rise) begin
            if (slot_start) begin
                shreg    <= '0;
                shreg[0] <= sd_s;
                if (chan == CH_LEFT) left_ok <= 1'b0;
            end else if (slot_cnt < LAST_PCM) begin
                shreg <= word[PCM_BITS-2:0];
            end
            if (word_done) begin
                if (chan == CH_LEFT) begin
                    left_hold <= word;
                    left_ok   <= 1'b1;
                end else begin
                    right_hold <= word;
                end
            end
            if (frame_done) left_ok <= 1'b0;
        end
    end

    // Present the pair with a one-cycle pulse; otherwise hold the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_valid <= 1'b0;
            left_pcm   <= '0;
            right_pcm  <= '0;
        end else begin
            pair_valid <= frame_done;
            if (frame_done) begin
                left_pcm  <= left_hold;
                right_pcm <= right_hold;
            end
        end
    end
endmodule

// File: rtl/i2s_slave_rx.sv
// Top of the stereo serial audio slave receiver. It connects the
// synchronizer, the slot framer and the sample assembler. The bit clock
// and word select come from an external master and are oversampled by
// clk. msb_justified selects the alignment of the MSB to the word-select edge.
module i2s_slave_rx
    import i2s_rx_pkg::*;
#(
    parameter int SLOT_BITS   = SLOT_BITS_DEF,
    parameter int PCM_BITS    = PCM_BITS_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msb_justified,
    input  logic                bclk_in,
    input  logic                ws_in,
    input  logic                sd_in,
    output logic [PCM_BITS-1:0] left_pcm,
    output logic [PCM_BITS-1:0] right_pcm,
    output logic                pair_valid
);
    localparam int CNT_W = $clog2(SLOT_BITS + 1);

    logic             bit_rise;
    logic             ws_s;
    logic             sd_s;
    chan_e            cur_chan;
    logic             slot_start;
    logic [CNT_W-1:0] slot_cnt;

    i2s_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_in  (bclk_in),
        .ws_in    (ws_in),
        .sd_in    (sd_in),
        .bit_rise (bit_rise),
        .ws_s     (ws_s),
        .sd_s     (sd_s)
    );

    i2s_rx_framer #(.SLOT_BITS(SLOT_BITS), .CNT_W(CNT_W)) u_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .msb_justified (msb_justified),
        .bit_rise      (bit_rise),
        .ws_s          (ws_s),
        .chan          (cur_chan),
        .slot_start    (slot_start),
        .slot_cnt      (slot_cnt)
    );

    i2s_rx_assembler #(.SLOT_BITS(SLOT_BITS), .PCM_BITS(PCM_BITS), .CNT_W(CNT_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_rise   (bit_rise),
        .slot_start (slot_start),
        .chan       (cur_chan),
        .slot_cnt   (slot_cnt),
        .sd_s       (sd_s),
        .pair_valid (pair_valid),
        .left_pcm   (left_pcm),
        .right_pcm  (right_pcm)
    );
endmodule

// File: rtl/i2s_rx_chk.sv
// Protocol checks for the receiver, bound to its top. They relate the
// output pulse and output data to the framer's state and the
// synchronizer's edge strobe.
module i2s_rx_chk #(
    parameter int SLOT_BITS = 32,
    parameter int PCM_BITS  = 16,
    parameter int CNT_W     = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_rise,
    input logic                chan,
    input logic [CNT_W-1:0]    slot_cnt,
    input logic                pair_valid,
    input logic [PCM_BITS-1:0] left_pcm,
    input logic [PCM_BITS-1:0] right_pcm
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOT_BITS - 1);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pair_valid && left_pcm == '0 && right_pcm == '0));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R7
    pulse_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(bit_rise));

    // R5
    pulse_in_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(chan) == 1'b1);

    // R9
    pulse_at_slot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(slot_cnt) == LAST_SLOT);

    // R8
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_pcm) && $stable(right_pcm)));
endmodule

bind i2s_slave_rx i2s_rx_chk #(
    .SLOT_BITS (SLOT_BITS),
    .PCM_BITS  (PCM_BITS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_rise   (bit_rise),
    .chan       (cur_chan),
    .slot_cnt   (slot_cnt),
    .pair_valid (pair_valid),
    .left_pcm   (left_pcm),
    .right_pcm  (right_pcm)
);

// File: tb/tb_i2s_slave_rx.sv
// Bench: builds bit streams behaviourally, drives them as a master would,
// and compares every cycle against the predicted pulse times and samples.
module tb_i2s_slave_rx;
    localparam int LAT = 3;  // synchronizer stages + output register

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msb_justified = 1'b0;
    logic        bclk_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        sd_in = 1'b0;
    logic [15:0] left_pcm;
    logic [15:0] right_pcm;
    logic        pair_valid;

    int checks = 0;
    int failures = 0;
    int pc = 0;

    int          bit_c[$];
    logic        bit_d[$];
    logic        bit_m[$];
    logic [15:0] pend_l[$];
    logic [15:0] pend_r[$];
    int          ev_t[$];
    logic [15:0] ev_l[$];
    logic [15:0] ev_r[$];
    logic [15:0] last_l = '0;
    logic [15:0] last_r = '0;
    logic [15:0] prev_lo = '0;
    logic [15:0] prev_ro = '0;
    string       mode_tag = "R3";

    always #2 clk = ~clk;

    i2s_slave_rx dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .msb_justified (msb_justified),
        .bclk_in       (bclk_in),
        .ws_in         (ws_in),
        .sd_in         (sd_in),
        .left_pcm      (left_pcm),
        .right_pcm     (right_pcm),
        .pair_valid    (pair_valid)
    );

    task automatic add_slot(input int c, input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            bit_c.push_back(c);
            bit_d.push_back(w[31-i]);
            bit_m.push_back(1'b0);
        end
    endtask

    task automatic add_frame(input logic [31:0] l, input logic [31:0] r);
        add_slot(0, l, 32);
        add_slot(1, r, 32);
        bit_m[bit_m.size()-1] = 1'b1;
        pend_l.push_back(l[31:16]);
        pend_r.push_back(r[31:16]);
    endtask

    // Drive the queued stream; standard mode moves word select one bit earlier.
    task automatic run_stream(input bit std_mode);
        for (int j = 0; j < bit_c.size(); j++) begin
            @(negedge clk);
            bclk_in = 1'b0;
            if (std_mode && (j + 1 < bit_c.size())) ws_in = bit_c[j+1][0];
            else ws_in = bit_c[j][0];
            sd_in = bit_d[j];
            repeat (3) @(negedge clk);
            @(negedge clk);
            bclk_in = 1'b1;
            if (bit_m[j]) begin
                ev_t.push_back(pc + LAT);
                ev_l.push_back(pend_l.pop_front());
                ev_r.push_back(pend_r.pop_front());
            end
            @(negedge clk);
            sd_in = ~sd_in;  // R2: change while the bit clock is high
            repeat (2) @(negedge clk);
        end
        bit_c.delete();
        bit_d.delete();
        bit_m.delete();
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        msb_justified = mode;
        bclk_in = 1'b0;
        repeat (5) @(negedge clk);
        // R1: outputs cleared by reset
        checks++;
        if (pair_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 pair_valid actual=%0b expected=0", pair_valid);
        end
        checks++;
        if (left_pcm !== 16'h0 || right_pcm !== 16'h0) begin
            failures++;
            $display("FAIL R1 outputs actual=%h/%h expected=0000/0000", left_pcm, right_pcm);
        end
        rst_n = 1'b1;
    endtask

    task automatic build_tests();
        add_slot(1, 32'h0, 8);                      // idle, right level
        add_frame(32'h8000_0001, 32'h7FFF_FFFE);    // R3 R4 MSB alignment
        add_frame(32'hA5A5_3C3C, 32'h5A5A_C3C3);    // R5 channel order
        add_frame(32'h1234_FFFF, 32'hFEDC_0000);    // R6 low half ignored
        add_slot(0, 32'hFFFF_FFFF, 10);             // R9 short left slot
        add_slot(1, 32'hFFFF_FFFF, 32);
        add_frame(32'h0001_8000, 32'h8000_7FFF);
        add_slot(0, 32'h4321_0000, 32);             // R9 short right slot
        add_slot(1, 32'hCAFE_0000, 20);
        add_frame(32'hFFFF_0000, 32'h0000_FFFF);
        add_slot(0, 32'h0, 4);                      // trailing idle
    endtask

    // Compare with the prediction once per cycle, away from the clock edges.
    always @(posedge clk) begin
        #1;
        pc++;
        if (!rst_n) begin
            last_l = '0;
            last_r = '0;
        end else if (ev_t.size() > 0 && ev_t[0] == pc) begin
            checks++;
            if (pair_valid !== 1'b1) begin
                failures++;
                $display("FAIL R7 pulse at cycle %0d actual=%0b expected=1", pc, pair_valid);
            end
            checks++;
            if (left_pcm !== ev_l[0] || right_pcm !== ev_r[0]) begin
                failures++;
                $display("FAIL %s R5 R6 R2 data actual=%h/%h expected=%h/%h",
                         mode_tag, left_pcm, right_pcm, ev_l[0], ev_r[0]);
            end
            checks++;
            if (prev_lo !== last_l || prev_ro !== last_r) begin
                failures++;
                $display("FAIL R8 held outputs actual=%h/%h expected=%h/%h",
                         prev_lo, prev_ro, last_l, last_r);
            end
            last_l = ev_l.pop_front();
            last_r = ev_r.pop_front();
            void'(ev_t.pop_front());
        end else if (pair_valid === 1'b1) begin
            checks++;
            failures++;
            $display("FAIL R9 unexpected pulse at cycle %0d actual=1 expected=0", pc);
        end
        prev_lo = left_pcm;
        prev_ro = right_pcm;
    end

    initial begin
        do_reset(1'b0);
        mode_tag = "R3";
        build_tests();
        run_stream(1'b1);
        do_reset(1'b1);
        mode_tag = "R4";
        build_tests();
        run_stream(1'b0);
        // R7: every predicted pulse was seen
        checks++;
        if (ev_t.size() != 0) begin
            failures++;
            $display("FAIL R7 missing pulses actual=%0d expected=0", ev_t.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule